// File: doc/BRIEF.md
# Four-State Debug Trigger Sequencer

This block steps a debug session through a short programmable chain of states and, when the chain completes, raises a one-cycle trace-session trigger together with a breakpoint request of a selectable kind. It watches match pulses from four external comparators and moves from state to state as those matches occur. Each step takes effect in one of two ways. A tagged step waits until the matched instruction is about to start executing. A forced step waits for the next instruction boundary after the match. An immediate software trigger skips the comparators and completes the chain at once.

The sequencer has an idle state, three programmable active states (S1, S2, S3) and a final state. Software arms it with a level input. While armed, the sequencer leaves idle for S1. In each active state a configuration pair names the comparator to watch and the state to go to next. The final state holds until the sequencer is disarmed. Dropping the arm input at any time sends the sequencer back to idle and discards any step still waiting to take effect. The named transitions are: ARM (idle to S1), STEP (active state to its programmed successor, taken when a waiting tagged or forced match is consumed), SWTRIG (active state to final), DISARM (any state to idle) and HOLD (final to final).

Top module: `trig_sequencer`

## Requirements
- R1: While reset is low and on the first cycle after it, cur_state reads 0 (idle), and trace_trig, brk_req and brk_sel are all 0. cur_state uses this encoding: 0 idle, 1 S1, 2 S2, 3 S3, 4 final.
- R2: If arm is high in idle, cur_state becomes S1 at the next clock edge. If arm is low in any state, cur_state becomes idle at the next edge and any waiting step is discarded, so a later tag_start or insn_bnd causes no move.
- R3: In active state Sn (n = 1..3), only comparator step_cmp[n-1] can cause a move, and its target is given by step_nxt[n-1]: 1, 2 and 3 select S1, S2 and S3, and 0 selects final. Matches on every other comparator have no effect.
- R4: When the selected comparator has cmp_tagged[c] = 0 (forced), its match is held as waiting. The move happens at the first clock edge after the match cycle on which insn_bnd is high. A boundary in the match cycle itself does not count, and tag_start has no effect on a forced step.
- R5: When the selected comparator has cmp_tagged[c] = 1 (tagged), its match is held as waiting. The move happens at the first edge after the match cycle on which tag_start is high. insn_bnd has no effect on a tagged step.
- R6: sw_trig high in S1, S2 or S3 (while armed) moves the sequencer to final at the next edge, whatever the comparators show. sw_trig is ignored in idle and in final.
- R7: On entry to final, trace_trig and brk_req are high for exactly the first cycle in which cur_state reads 4. In that same cycle brk_sel takes the value of brk_type sampled at the entering edge (0 debug-mode entry, 1 software interrupt, 2 coprocessor breakpoint; a value of 3 is recorded as 0). brk_sel then holds that value until the next entry to final. Final persists while arm stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Level arming control |
| cmp_match | input | 4 | Per-comparator match pulses |
| cmp_tagged | input | 4 | Per-comparator step mode: 1 tagged, 0 forced |
| insn_bnd | input | 1 | Instruction-boundary strobe |
| tag_start | input | 1 | Strobe: the tagged instruction is about to start |
| sw_trig | input | 1 | Immediate software trigger pulse |
| step_cmp | input | 3x2 | Comparator index watched in S1..S3 |
| step_nxt | input | 3x2 | Successor code for S1..S3 (0 means final) |
| brk_type | input | 2 | Requested breakpoint kind |
| trace_trig | output | 1 | One-cycle trace-session trigger |
| brk_req | output | 1 | One-cycle breakpoint request |
| brk_sel | output | 2 | Breakpoint kind recorded at the last entry to final |
| cur_state | output | 3 | Current sequencer state |

## Verification
The bench targets several corner cases. A match and its consuming strobe can arrive in the same cycle; a design that consumes at once would move one step too early. A strobe of the wrong kind can arrive for the pending mode; a design that mixes up tagged and forced would move on a boundary or tag start it should ignore. Other checks cover a match pending across a disarm and re-arm, which a leaky design would act on as a stale step, and a software trigger in idle or final, where a careless design would re-arm or pulse a second trigger. It also checks that a later change to brk_type after entry does not alter the recorded brk_sel, and that a reserved brk_type value is mapped to 0.

// File: rtl/dbgseq_pkg.sv
package dbgseq_pkg;

    // Sequencer states; cur_state exposes this encoding directly.
    typedef enum logic [2:0] {
        SQ_IDLE  = 3'd0,
        SQ_ONE   = 3'd1,
        SQ_TWO   = 3'd2,
        SQ_THREE = 3'd3,
        SQ_FINAL = 3'd4
    } seq_state_e;

    // Breakpoint kinds reported on brk_sel.
    typedef enum logic [1:0] {
        BK_DBGMODE = 2'd0,
        BK_SWINT   = 2'd1,
        BK_COPROC  = 2'd2
    } brk_kind_e;

    // Number of programmable active states.
    localparam int unsigned N_STEP = 3;

    // Successor field: 1..3 select an active state, 0 selects final.
    function automatic seq_state_e decode_next(input logic [1:0] code);
        seq_state_e r;
        unique case (code)
            2'd1:    r = SQ_ONE;
            2'd2:    r = SQ_TWO;
            2'd3:    r = SQ_THREE;
            default: r = SQ_FINAL;
        endcase
        return r;
    endfunction

    // Reserved kind value 3 falls back to debug-mode entry.
    function automatic brk_kind_e decode_kind(input logic [1:0] code);
        brk_kind_e r;
        unique case (code)
            2'd1:    r = BK_SWINT;
            2'd2:    r = BK_COPROC;
            default: r = BK_DBGMODE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/seq_cond_sel.sv
module seq_cond_sel
    import dbgseq_pkg::*;
#(
    parameter int N_CMP = 4,
    parameter int IDX_W = 2
) (
    input  seq_state_e                           state,
    input  logic [N_STEP-1:0][IDX_W-1:0]         step_cmp,
    input  logic [N_STEP-1:0][1:0]               step_nxt,
    input  logic [N_CMP-1:0]                     cmp_match,
    input  logic [N_CMP-1:0]                     cmp_tagged,
    output logic                                 sel_hit,
    output logic                                 sel_tagged,
    output seq_state_e                           sel_next,
    output logic                                 active
);

    logic [N_STEP-1:0] st_hit;
    logic [N_STEP-1:0] st_tag;

    // One comparator selector per active state.
    for (genvar g = 0; g < N_STEP; g++) begin : g_step
        logic hit_g;
        logic tag_g;
        always_comb begin
            hit_g = 1'b0;
            tag_g = 1'b0;
            for (int k = 0; k < N_CMP; k++) begin
                if (step_cmp[g] == k[IDX_W-1:0]) begin
                    hit_g = cmp_match[k];
                    tag_g = cmp_tagged[k];
                end
            end
        end
        assign st_hit[g] = hit_g;
        assign st_tag[g] = tag_g;
    end

    always_comb begin
        sel_hit    = 1'b0;
        sel_tagged = 1'b0;
        sel_next   = SQ_FINAL;
        active     = 1'b0;
        unique case (state)
            SQ_ONE: begin
                sel_hit    = st_hit[0];
                sel_tagged = st_tag[0];
                sel_next   = decode_next(step_nxt[0]);
                active     = 1'b1;
            end
            SQ_TWO: begin
                sel_hit    = st_hit[1];
                sel_tagged = st_tag[1];
                sel_next   = decode_next(step_nxt[1]);
                active     = 1'b1;
            end
            SQ_THREE: begin
                sel_hit    = st_hit[2];
                sel_tagged = st_tag[2];
                sel_next   = decode_next(step_nxt[2]);
                active     = 1'b1;
            end
            default: begin
                sel_hit = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/seq_pend.sv
module seq_pend (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic hit,
    input  logic hit_tagged,
    input  logic insn_bnd,
    input  logic tag_start,
    output logic pending,
    output logic consume
);

    logic pend_q;
    logic pend_tag_q;

    // A waiting step is consumed only by the strobe matching its kind.
    assign consume = pend_q && (pend_tag_q ? tag_start : insn_bnd);
    assign pending = pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q     <= 1'b0;
            pend_tag_q <= 1'b0;
        end else if (clear || consume) begin
            pend_q     <= 1'b0;
            pend_tag_q <= 1'b0;
        end else if (!pend_q && hit) begin
            pend_q     <= 1'b1;
            pend_tag_q <= hit_tagged;
        end
    end

    // R2: a clear discards the waiting step.
    p_clear_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !pending);

    // R4: a consumed step does not linger.
    p_consume_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (consume && !clear) |=> !pending);

    // R5: a waiting step stays until consumed or cleared.
    p_pend_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !consume && !clear) |=> pending);

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
    import dbgseq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        arm,
    input  logic        sw_trig,
    input  logic        consume,
    input  seq_state_e  sel_next,
    input  logic [1:0]  brk_type,
    output seq_state_e  state,
    output logic        fire,
    output brk_kind_e   brk_sel
);

    seq_state_e state_q;
    seq_state_e state_nxt;
    logic       fire_q;
    brk_kind_e  kind_q;

    // Next-state selection with named transitions.
    always_comb begin
        state_nxt = state_q;
        if (!arm) begin
            state_nxt = SQ_IDLE;                       // DISARM
        end else begin
            unique case (state_q)
                SQ_IDLE:  state_nxt = SQ_ONE;          // ARM
                SQ_ONE, SQ_TWO, SQ_THREE: begin
                    if (sw_trig)      state_nxt = SQ_FINAL; // SWTRIG
                    else if (consume) state_nxt = sel_next; // STEP
                end
                SQ_FINAL: state_nxt = SQ_FINAL;        // HOLD
                default:  state_nxt = SQ_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SQ_IDLE;
        else        state_q <= state_nxt;
    end

    // Output register: pulse and kind captured on entry to final.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fire_q <= 1'b0;
            kind_q <= BK_DBGMODE;
        end else begin
            fire_q <= (state_nxt == SQ_FINAL) && (state_q != SQ_FINAL);
            if ((state_nxt == SQ_FINAL) && (state_q != SQ_FINAL))
                kind_q <= decode_kind(brk_type);
        end
    end

    assign state   = state_q;
    assign fire    = fire_q;
    assign brk_sel = kind_q;

    // R2: disarm returns to idle.
    p_disarm_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |=> state == SQ_IDLE);

    // R2: arming leaves idle for S1.
    p_arm_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && state == SQ_IDLE) |=> state == SQ_ONE);

    // R6: software trigger from an active state completes the chain.
    p_sw_final_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && sw_trig && state != SQ_IDLE) |=> state == SQ_FINAL);

    // R7: final is held while armed.
    p_final_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && state == SQ_FINAL) |=> state == SQ_FINAL);

    // R7: the pulse marks the first cycle in final only.
    p_fire_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (state == SQ_FINAL && $past(state) != SQ_FINAL));

    p_entry_fire_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_FINAL && $past(state) != SQ_FINAL) |-> fire);

endmodule

// File: rtl/trig_sequencer.sv
module trig_sequencer
    import dbgseq_pkg::*;
#(
    parameter int N_CMP = 4,
    localparam int IDX_W = (N_CMP > 1) ? $clog2(N_CMP) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         arm,
    input  logic [N_CMP-1:0]             cmp_match,
    input  logic [N_CMP-1:0]             cmp_tagged,
    input  logic                         insn_bnd,
    input  logic                         tag_start,
    input  logic                         sw_trig,
    input  logic [N_STEP-1:0][IDX_W-1:0] step_cmp,
    input  logic [N_STEP-1:0][1:0]       step_nxt,
    input  logic [1:0]                   brk_type,
    output logic                         trace_trig,
    output logic                         brk_req,
    output logic [1:0]                   brk_sel,
    output logic [2:0]                   cur_state
);

    seq_state_e state;
    seq_state_e sel_next;
    brk_kind_e  kind;
    logic       sel_hit;
    logic       sel_tagged;
    logic       active;
    logic       pending;
    logic       consume;
    logic       fire;
    logic       pend_clear;

    assign pend_clear = !arm || sw_trig || !active;

    seq_cond_sel #(.N_CMP(N_CMP), .IDX_W(IDX_W)) i_sel (
        .state      (state),
        .step_cmp   (step_cmp),
        .step_nxt   (step_nxt),
        .cmp_match  (cmp_match),
        .cmp_tagged (cmp_tagged),
        .sel_hit    (sel_hit),
        .sel_tagged (sel_tagged),
        .sel_next   (sel_next),
        .active     (active)
    );

    seq_pend i_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (pend_clear),
        .hit        (sel_hit),
        .hit_tagged (sel_tagged),
        .insn_bnd   (insn_bnd),
        .tag_start  (tag_start),
        .pending    (pending),
        .consume    (consume)
    );

    seq_fsm i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (arm),
        .sw_trig  (sw_trig),
        .consume  (consume),
        .sel_next (sel_next),
        .brk_type (brk_type),
        .state    (state),
        .fire     (fire),
        .brk_sel  (kind)
    );

    assign trace_trig = fire;
    assign brk_req    = fire;
    assign brk_sel    = kind;
    assign cur_state  = state;

    // R3: without a consumed step or software trigger an active state holds.
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && active && !sw_trig && !consume) |=> $stable(cur_state));

    // R4: a move between active states needs a waiting step.
    p_step_needs_pend_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && active && !sw_trig && !pending) |=> $stable(cur_state));

endmodule

// File: tb/test_trig_sequencer.sv
module test_trig_sequencer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       arm = 1'b0;
    logic [3:0] cmp_match = '0;
    logic [3:0] cmp_tagged = 4'b0100;
    logic       insn_bnd = 1'b0;
    logic       tag_start = 1'b0;
    logic       sw_trig = 1'b0;
    logic [2:0][1:0] step_cmp;
    logic [2:0][1:0] step_nxt;
    logic [1:0] brk_type = 2'd1;
    logic       trace_trig;
    logic       brk_req;
    logic [1:0] brk_sel;
    logic [2:0] cur_state;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    trig_sequencer i_trig_sequencer (
        .clk(clk), .rst_n(rst_n), .arm(arm), .cmp_match(cmp_match),
        .cmp_tagged(cmp_tagged), .insn_bnd(insn_bnd), .tag_start(tag_start),
        .sw_trig(sw_trig), .step_cmp(step_cmp), .step_nxt(step_nxt),
        .brk_type(brk_type), .trace_trig(trace_trig), .brk_req(brk_req),
        .brk_sel(brk_sel), .cur_state(cur_state)
    );

    // Vector: arm | match[3:0] | bnd | tag | sw | exp_state[2:0] | exp_trig
    localparam int NV = 23;
    localparam logic [11:0] VEC [NV] = '{
        12'b1_0000_0_0_0_001_0,  // R2 arm -> S1
        12'b1_0100_0_1_0_001_0,  // R5 tagged match with same-cycle tag: wait
        12'b1_0000_1_0_0_001_0,  // R5 boundary ignored for tagged
        12'b1_0000_0_1_0_011_0,  // R5 tag start -> S3
        12'b1_1000_1_0_0_011_0,  // R4 forced match with same-cycle boundary: wait
        12'b1_0001_0_0_0_011_0,  // R3 other comparator ignored
        12'b1_0000_0_1_0_011_0,  // R4 tag start ignored for forced
        12'b1_0000_1_0_0_010_0,  // R4 boundary -> S2
        12'b1_1000_1_0_0_010_0,  // R3 unselected comparator ignored
        12'b1_0001_0_0_0_010_0,  // R4 match latched
        12'b1_0000_1_0_0_100_1,  // R3 code 0 -> final, R7 pulse
        12'b1_0000_0_0_0_100_0,  // R7 single pulse, held
        12'b1_0000_0_0_1_100_0,  // R6 sw ignored in final
        12'b0_0000_0_0_0_000_0,  // R2 disarm
        12'b0_0000_0_0_1_000_0,  // R6 sw ignored in idle
        12'b1_0000_0_0_1_001_0,  // R6 sw ignored at arming
        12'b1_0000_0_0_1_100_1,  // R6 sw from S1 -> final
        12'b0_0000_0_0_0_000_0,  // R2 disarm
        12'b1_0000_0_0_0_001_0,  // R2 rearm
        12'b1_0100_0_0_0_001_0,  // R5 match waiting
        12'b0_0000_0_0_0_000_0,  // R2 disarm drops it
        12'b1_0000_0_0_0_001_0,  // R2 rearm
        12'b1_0000_0_1_0_001_0   // R2 stale step not taken
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        cmp_match = '0; insn_bnd = 1'b0; tag_start = 1'b0; sw_trig = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        step_cmp[0] = 2'd2; step_nxt[0] = 2'd3;
        step_cmp[1] = 2'd0; step_nxt[1] = 2'd0;
        step_cmp[2] = 2'd3; step_nxt[2] = 2'd2;
        @(negedge clk);
        tick();
        // R1: reset state
        chk("R1", "state in reset", int'(cur_state), 0);
        chk("R1", "trig in reset", int'(trace_trig), 0);
        chk("R1", "brk_req in reset", int'(brk_req), 0);
        chk("R1", "brk_sel in reset", int'(brk_sel), 0);
        rst_n = 1'b1;
        tick();
        chk("R1", "state after reset", int'(cur_state), 0);

        // Vector walk
        for (int v = 0; v < NV; v++) begin
            arm       = VEC[v][11];
            cmp_match = VEC[v][10:7];
            insn_bnd  = VEC[v][6];
            tag_start = VEC[v][5];
            sw_trig   = VEC[v][4];
            tick();
            chk("R3-vec", $sformatf("vec %0d state", v), int'(cur_state), int'(VEC[v][3:1]));
            chk("R7", $sformatf("vec %0d trig", v), int'(trace_trig), int'(VEC[v][0]));
            chk("R7", $sformatf("vec %0d brk_req", v), int'(brk_req), int'(VEC[v][0]));
            if (VEC[v][0]) chk("R7", $sformatf("vec %0d brk_sel", v), int'(brk_sel), 1);
        end
        idle_inputs();

        // R7: coprocessor kind captured, then held across brk_type change
        arm = 1'b1; tick();                         // S1
        brk_type = 2'd2; sw_trig = 1'b1; tick(); sw_trig = 1'b0;
        chk("R7", "kind coproc", int'(brk_sel), 2);
        chk("R7", "req on entry", int'(brk_req), 1);
        brk_type = 2'd0; tick();
        chk("R7", "kind held", int'(brk_sel), 2);
        chk("R7", "req drops", int'(brk_req), 0);

        // R7: reserved kind recorded as 0
        arm = 1'b0; tick(); arm = 1'b1; tick();
        brk_type = 2'd3; sw_trig = 1'b1; tick(); sw_trig = 1'b0;
        chk("R7", "reserved kind", int'(brk_sel), 0);
        chk("R7", "trig reserved", int'(trace_trig), 1);

        // R3: alternate config, S1 straight to final via forced comparator 1
        arm = 1'b0; tick();
        step_cmp[0] = 2'd1; step_nxt[0] = 2'd0; brk_type = 2'd1;
        arm = 1'b1; tick();
        cmp_match = 4'b0100; tick(); cmp_match = '0;  // comparator 2 not selected
        insn_bnd = 1'b1; tick(); insn_bnd = 1'b0;
        chk("R3", "unselected comparator", int'(cur_state), 1);
        cmp_match = 4'b0010; tick(); cmp_match = '0;
        chk("R4", "waiting before boundary", int'(cur_state), 1);
        tick();
        chk("R4", "no boundary yet", int'(cur_state), 1);
        insn_bnd = 1'b1; tick(); insn_bnd = 1'b0;
        chk("R3", "S1 to final", int'(cur_state), 4);
        chk("R7", "trig alt", int'(trace_trig), 1);

        // R3: self loop S1 -> S1
        arm = 1'b0; tick();
        step_nxt[0] = 2'd1; arm = 1'b1; tick();
        cmp_match = 4'b0010; tick(); cmp_match = '0;
        insn_bnd = 1'b1; tick(); insn_bnd = 1'b0;
        chk("R3", "self loop", int'(cur_state), 1);
        chk("R3", "no trig on loop", int'(trace_trig), 0);

        // R1: reset mid-run
        rst_n = 1'b0; tick();
        chk("R1", "reset mid-run", int'(cur_state), 0);
        chk("R1", "brk_sel cleared", int'(brk_sel), 0);
        rst_n = 1'b1; arm = 1'b0; tick();

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule